// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides a 2N-bit unsigned dividend by an N-bit unsigned divisor over several clock cycles. It returns an N-bit quotient and an N-bit remainder. The default width is N=32. The remainder and the quotient are built in one left-shifting register that is 2N+1 bits wide. The extra top bit keeps a one that a shift pushes out of the upper half. One subtractor, N+1 bits wide, compares the divisor with the upper half on every clock.

The operation starts with a single pulse on `start`. On that edge the block checks the operands. If the quotient cannot fit in N bits, or the divisor is zero, the block reports overflow one cycle later without iterating. Otherwise it loads the dividend and applies the first left shift in the same step. It then runs N trial-subtract steps, one per clock, and pulses `done`. The remainder is read from the upper half with a one-bit right correction. The quotient is read from the lower half.

Top module: `seq_udiv`

## Requirements
- R1: While reset is held and in the cycle that follows it, `busy`, `done` and `ovf` are all 0.
- R2: A start is accepted when `start` is 1 and `busy` is 0. When it is accepted with upper dividend half < divisor, `busy` is 1 for exactly N cycles starting the cycle after. `done` is then 1 for one cycle with `busy` at 0, N+1 cycles after acceptance.
- R3: A start is accepted with upper dividend half >= divisor, which includes a divisor of 0. In the next cycle `done`=1 and `ovf`=1, and `busy` stays 0.
- R4: After a run without overflow, `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor, with remainder < divisor. Both stay stable until the next accepted start.
- R5: A `start` pulse while `busy` is 1 is ignored. The run completes on its original cycle, and its results come from the operands captured at acceptance.
- R6: `ovf` keeps its value until the next accepted start. An accepted start without overflow clears it.
- R7: With N=4, 0x74 / 0x9 gives quotient 0xC and remainder 0x8.
- R8: A divisor of d with upper dividend half d-1 and lower half all ones gives quotient all ones. This case needs the extra top bit of the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division (accepted when not busy) |
| dividend | input | 2N | Unsigned dividend, sampled at acceptance |
| divisor | input | N | Unsigned divisor, sampled at acceptance |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Quotient not representable or divisor zero |
| quotient | output | N | Quotient result |
| remainder | output | N | Remainder result |

## Verification
The bound checker applies the following checks on every cycle:
- A non-overflow start leads to exactly N busy cycles and then a clean `done`.
- An overflowing start gives `done` and `ovf` one cycle later without `busy`.
- `ovf` cannot change during a run.
- Each completed result satisfies dividend = divisor × quotient + remainder with remainder < divisor, against the operands captured at acceptance.

Only the bench scenarios can show the following:
- The exact known values for the small-width example and for the all-ones quotient.
- That results persist across idle cycles.
- That an interfering start while busy leaves both timing and results untouched.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic {
        UD_IDLE = 1'b0,
        UD_RUN  = 1'b1
    } udiv_state_e;

    // Per-cycle commands from the controller to the datapath
    typedef struct packed {
        logic load;   // capture operands and apply the pre-shift
        logic step;   // one trial-subtract and shift
    } udiv_cmd_t;

endpackage

// File: rtl/udiv_range_chk.sv
module udiv_range_chk #(
    parameter int N = 32
) (
    input  logic [N-1:0] dividend_hi,
    input  logic [N-1:0] divisor,
    output logic         fits
);
    // Quotient fits in N bits only when the upper half is below the divisor.
    // A zero divisor can never satisfy this.
    always_comb begin
        fits = (divisor != '0) && (dividend_hi < divisor);
    end
endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      fits,
    output udiv_cmd_t cmd,
    output logic      busy,
    output logic      done,
    output logic      ovf
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    udiv_state_e   state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= UD_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                UD_IDLE: begin
                    if (start) begin
                        ovf <= ~fits;
                        if (fits) begin
                            state <= UD_RUN;
                            cnt   <= '0;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                UD_RUN: begin
                    if (cnt == LAST) begin
                        state <= UD_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= UD_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state == UD_RUN);
        cmd.load = (state == UD_IDLE) && start && fits;
        cmd.step = (state == UD_RUN);
    end
endmodule

// File: rtl/udiv_path.sv
module udiv_path
    import udiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  udiv_cmd_t     cmd,
    input  logic [2*N-1:0] dividend,
    input  logic [N-1:0]  divisor,
    output logic [N-1:0]  quotient,
    output logic [N-1:0]  remainder
);
    localparam int AW = 2 * N + 1;

    logic [AW-1:0] acc;      // extra top bit, remainder half, quotient half
    logic [N-1:0]  dvs_q;    // divisor captured at acceptance
    logic [N:0]    upper;
    logic [N+1:0]  diff;
    logic          short;    // trial subtraction went negative

    always_comb begin
        upper = acc[AW-1:N];
        diff  = {1'b0, upper} - {2'b00, dvs_q};
        short = diff[N+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            dvs_q <= '0;
        end else if (cmd.load) begin
            acc   <= {dividend, 1'b0};
            dvs_q <= divisor;
        end else if (cmd.step) begin
            if (short) begin
                // restore: keep the old upper half, insert quotient bit 0
                acc <= {acc[AW-2:0], 1'b0};
            end else begin
                acc <= {diff[N-1:0], acc[N-1:0], 1'b1};
            end
        end
    end

    // Upper half carries one shift too many: read it one bit higher
    always_comb begin
        quotient  = acc[N-1:0];
        remainder = acc[AW-1:N+1];
    end
endmodule

// File: rtl/seq_udiv.sv
module seq_udiv
    import udiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2*N-1:0] dividend,
    input  logic [N-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic           ovf,
    output logic [N-1:0]   quotient,
    output logic [N-1:0]   remainder
);
    udiv_cmd_t cmd;
    logic      fits;

    udiv_range_chk #(.N(N)) u_range (
        .dividend_hi (dividend[2*N-1:N]),
        .divisor     (divisor),
        .fits        (fits)
    );

    udiv_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .fits  (fits),
        .cmd   (cmd),
        .busy  (busy),
        .done  (done),
        .ovf   (ovf)
    );

    udiv_path #(.N(N)) u_path (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );
endmodule

// File: rtl/udiv_props.sv
module udiv_props #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [2*N-1:0] dividend,
    input logic [N-1:0]   divisor,
    input logic           busy,
    input logic           done,
    input logic           ovf,
    input logic [N-1:0]   quotient,
    input logic [N-1:0]   remainder
);
    localparam int W2 = 2 * N;

    logic [31:0]   run_len;
    logic [W2-1:0] dd_l;
    logic [N-1:0]  dv_l;
    logic [W2-1:0] rebuilt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            dd_l    <= '0;
            dv_l    <= '0;
        end else begin
            run_len <= busy ? run_len + 1 : '0;
            if (start && !busy) begin
                dd_l <= dividend;
                dv_l <= divisor;
            end
        end
    end

    always_comb begin
        rebuilt = W2'(quotient) * W2'(dv_l) + W2'(remainder);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && dividend[2*N-1:N] < divisor) |=> (busy && !ovf && !done)); // R2

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == N)); // R2

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && !ovf)); // R2

    AST_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && dividend[2*N-1:N] >= divisor) |=> (done && ovf && !busy)); // R3

    AST_RESULT_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (done && !ovf) |-> (rebuilt == dd_l && remainder < dv_l)); // R4

    AST_OVF_STABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ovf)); // R6
endmodule

bind seq_udiv udiv_props #(.N(N)) u_props (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .ovf       (ovf),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/seq_udiv_test.sv
module seq_udiv_test;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2*N-1:0] dividend = '0;
    logic [N-1:0]   divisor = '0;
    logic busy, done, ovf;
    logic [N-1:0] quotient, remainder;

    logic       s4 = 1'b0;
    logic [7:0] dd4 = '0;
    logic [3:0] dv4 = '0;
    logic busy4, done4, ovf4;
    logic [3:0] q4, r4;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 4 ns period

    seq_udiv #(.N(N)) uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .ovf(ovf), .quotient(quotient), .remainder(remainder)
    );

    seq_udiv #(.N(4)) uut4 (
        .clk(clk), .rst(rst), .start(s4), .dividend(dd4), .divisor(dv4),
        .busy(busy4), .done(done4), .ovf(ovf4), .quotient(q4), .remainder(r4)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one operation; lat counts negedges after acceptance until done
    task automatic run_op(input logic [63:0] dd, input logic [31:0] dv, input bit intr,
                          output int lat, output bit busy_first, output int busy_cnt);
        @(negedge clk);
        dividend = dd; divisor = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        busy_first = busy;
        busy_cnt = busy ? 1 : 0;
        while (!done && lat < N + 10) begin
            if (intr && lat == 3) begin
                start = 1'b1; dividend = 64'hFFFF_FFFF_FFFF_FFFF; divisor = 32'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (busy) busy_cnt++;
        end
        start = 1'b0;
    endtask

    task automatic t_valid(input logic [63:0] dd, input logic [31:0] dv, input bit intr, input string tag);
        int lat, bc;
        bit bf;
        logic [63:0] eq, er;
        eq = dd / {32'd0, dv};
        er = dd % {32'd0, dv};
        run_op(dd, dv, intr, lat, bf, bc);
        check(lat == N + 1, {tag, " R2 done latency"}, lat, N + 1);
        check(bf && bc == N, {tag, " R2 busy cycles"}, bc, N);
        check(!busy && !ovf, {tag, " R6 ovf clear"}, ovf, 0);
        check(quotient == eq[31:0], {tag, " R4 quotient"}, quotient, eq);
        check(remainder == er[31:0], {tag, " R4 remainder"}, remainder, er);
        @(negedge clk);
        check(!done, {tag, " R2 done single pulse"}, done, 0);
        @(negedge clk);
        check(quotient == eq[31:0] && remainder == er[31:0], {tag, " R4 results held"}, quotient, eq);
    endtask

    task automatic t_overflow(input logic [63:0] dd, input logic [31:0] dv, input string tag);
        int lat, bc;
        bit bf;
        run_op(dd, dv, 1'b0, lat, bf, bc);
        check(lat == 1 && ovf, {tag, " R3 overflow flagged next cycle"}, lat, 1);
        check(!bf, {tag, " R3 no busy"}, bf, 0);
        repeat (3) @(negedge clk);
        check(ovf && !done, {tag, " R6 ovf held"}, ovf, 1);
    endtask

    task automatic t_reset();
        check(!busy && !done && !ovf, "R1 outputs idle in reset", {busy, done, ovf}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !ovf, "R1 outputs idle after reset", {busy, done, ovf}, 0);
    endtask

    task automatic t_small();
        int n;
        @(negedge clk);
        dd4 = 8'h74; dv4 = 4'h9; s4 = 1'b1;
        @(negedge clk);
        s4 = 1'b0;
        n = 0;
        while (!done4 && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(done4 && !ovf4, "R7 narrow run completes", done4, 1);
        check(q4 == 4'hC, "R7 narrow quotient", q4, 4'hC);
        check(r4 == 4'h8, "R7 narrow remainder", r4, 4'h8);
    endtask

    task automatic t_random(input int count);
        for (int i = 0; i < count; i++) begin
            logic [31:0] dv, hi, lo;
            dv = $urandom;
            if (dv == 0) dv = 32'd7;
            hi = $urandom % dv;
            lo = $urandom;
            t_valid({hi, lo}, dv, 1'b0, "random R4");
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();                                                  // R1
        t_valid(64'd116, 32'd9, 1'b0, "basic");                     // R2 R4
        t_overflow(64'h0000_0005_0000_0000, 32'd5, "hi equals dv"); // R3
        t_overflow(64'd12345, 32'd0, "zero divisor");               // R3 R6
        t_valid(64'h0000_0004_FFFF_FFFF, 32'd5, 1'b0, "after ovf"); // R6
        t_valid({32'hFFFF_FFF0, 32'hFFFF_FFFF}, 32'hFFFF_FFF1, 1'b0, "max quotient R8");
        t_valid(64'h0000_0000_0000_0003, 32'hFFFF_FFFF, 1'b0, "zero quotient");
        t_valid(64'h1234_5678_9ABC_DEF0, 32'h8000_0001, 1'b1, "start while busy R5");
        t_small();                                                  // R7
        t_random(40);                                               // R4
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule